// File: doc/BRIEF.md
# Registered Arithmetic Logic Unit with Per-Unit Operand Gating

This block is the integer execute stage of a processor datapath. Two operands and a three-bit operation code are captured in input registers. The captured operands are then steered into one of three functional units: a parallel-prefix adder/subtractor, a bitwise logic unit or a barrel shifter. The selected unit's result, together with a carry-out bit, is captured in an output register.

The carry network of the adder is a Sklansky prefix tree. It has log2(WIDTH) combining levels, so its depth grows with the log of the width and not linearly. Subtraction runs through the same tree: the second operand is inverted and the carry-in is set.

When the `GATE_IDLE` parameter is set, the operand router drives zero into every unit the opcode does not select. The idle units then do not toggle. An output selector picks the active unit's result. The width is a parameter. The default is 32 bits, and the block also works at 8 bits.

Top module: `gated_alu`

## Requirements
- R1: Operands and opcode are sampled on a rising edge. The matching result and carry appear on `res_q`/`cout_q` after the next rising edge, which gives a latency of two edges. Between those edges the outputs still hold the previous result.
- R2: Opcode 000 (add) yields `res_q = (a + b) mod 2^WIDTH`, and `cout_q` is the carry out of the top bit. The carry ripples correctly through all WIDTH bits, for example all ones plus one gives zero with carry 1.
- R3: Opcode 001 (subtract) yields `res_q = (a - b) mod 2^WIDTH`, computed as a + ~b + 1. `cout_q` is 1 exactly when no borrow occurs (a >= b, unsigned).
- R4: Opcodes 010, 011 and 100 yield bitwise AND, OR and XOR of a and b respectively.
- R5: Opcodes 101, 110 and 111 shift a left logically, right logically and right arithmetically (sign-filled). The shift amount is the low log2(WIDTH) bits of b, and amounts 0 and WIDTH-1 both behave correctly.
- R6: `cout_q` is 0 after any opcode other than 000 and 001.
- R7: When `rst` is high at a rising edge, the input and output registers clear to zero. At the next edge after that, `res_q` and `cout_q` are zero.
- R8: With `GATE_IDLE` set, every unit the registered opcode does not select receives all-zero operands, and so produces a zero output. This gating never alters the selected unit's result.
- R9: The adder's sum and carry equal the arithmetic sum of its operands and carry-in whenever the adder is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand; low log2(WIDTH) bits give the shift amount |
| op_in | input | 3 | Operation code (encoding in R2 to R5) |
| res_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry-out (add/subtract only) |

## Verification
Some behaviour is checked on every cycle by properties: the zero outputs of the gated idle units, the prefix adder against a plain arithmetic sum, the carry flag staying low for non-arithmetic opcodes, and the cleared outputs after reset. Other behaviour only the bench's scenarios can show, at the pins. This covers the two-edge latency, the result values of all eight opcodes across an 8-bit sweep over every first operand and every shift amount, and the 32-bit corners: the full-width carry chain, borrow on subtraction, and shifts by 0 and 31.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_SLL = 3'b101,
        OP_SRL = 3'b110,
        OP_SRA = 3'b111
    } alu_op_e;
endpackage

// File: rtl/prefix_adder.sv
module prefix_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int LV = $clog2(WIDTH);

    logic [WIDTH-1:0] half;
    logic [WIDTH-1:0] gen [0:LV];
    logic [WIDTH-1:0] prp [0:LV];

    assign half = x ^ y;

    // level 0: carry-in folded into bit 0 generate
    assign gen[0] = {x[WIDTH-1:1] & y[WIDTH-1:1], (x[0] & y[0]) | (half[0] & cin)};
    assign prp[0] = half;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (((i >> l) & 1) == 1) begin : g_comb
                localparam int J = ((i >> l) << l) - 1;
                assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][J]);
                assign prp[l+1][i] = prp[l][i] & prp[l][J];
            end else begin : g_pass
                assign gen[l+1][i] = gen[l][i];
                assign prp[l+1][i] = prp[l][i];
            end
        end
    end

    assign sum  = half ^ {gen[LV][WIDTH-2:0], cin};
    assign cout = gen[LV][WIDTH-1];
endmodule

// File: rtl/logic_unit.sv
module logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] z
);
    always_comb begin
        unique case (op)
            OP_AND:  z = x & y;
            OP_OR:   z = x | y;
            OP_XOR:  z = x ^ y;
            default: z = x & y;
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW = $clog2(WIDTH)
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] x,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] z
);
    always_comb begin
        unique case (op)
            OP_SLL:  z = x << amt;
            OP_SRL:  z = x >> amt;
            OP_SRA:  z = $unsigned($signed(x) >>> amt);
            default: z = x << amt;
        endcase
    end
endmodule

// File: rtl/gated_alu.sv
module gated_alu
    import alu_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit GATE_IDLE = 1'b1,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [2:0]       op_in,
    output logic [WIDTH-1:0] res_q,
    output logic             cout_q
);
    logic [WIDTH-1:0] a_q, b_q;
    alu_op_e          op_q;

    // input capture
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_ADD;
        end else begin
            a_q  <= a_in;
            b_q  <= b_in;
            op_q <= alu_op_e'(op_in);
        end
    end

    logic sel_add, sel_log, sel_shf, is_sub;
    assign sel_add = (op_q == OP_ADD) || (op_q == OP_SUB);
    assign sel_log = (op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR);
    assign sel_shf = (op_q == OP_SLL) || (op_q == OP_SRL) || (op_q == OP_SRA);
    assign is_sub  = (op_q == OP_SUB);

    // operand router
    logic [WIDTH-1:0] add_x, add_y, log_x, log_y, shf_x;
    logic [SHW-1:0]   shf_amt;
    logic             add_cin;

    if (GATE_IDLE) begin : g_gate
        assign add_x   = sel_add ? a_q : '0;
        assign add_y   = sel_add ? (is_sub ? ~b_q : b_q) : '0;
        assign add_cin = sel_add & is_sub;
        assign log_x   = sel_log ? a_q : '0;
        assign log_y   = sel_log ? b_q : '0;
        assign shf_x   = sel_shf ? a_q : '0;
        assign shf_amt = sel_shf ? b_q[SHW-1:0] : '0;
    end else begin : g_share
        assign add_x   = a_q;
        assign add_y   = is_sub ? ~b_q : b_q;
        assign add_cin = is_sub;
        assign log_x   = a_q;
        assign log_y   = b_q;
        assign shf_x   = a_q;
        assign shf_amt = b_q[SHW-1:0];
    end

    logic [WIDTH-1:0] add_z, log_z, shf_z;
    logic             add_co;

    prefix_adder #(.WIDTH(WIDTH)) adder_i (
        .x(add_x), .y(add_y), .cin(add_cin), .sum(add_z), .cout(add_co)
    );
    logic_unit #(.WIDTH(WIDTH)) logic_i (
        .op(op_q), .x(log_x), .y(log_y), .z(log_z)
    );
    shift_unit #(.WIDTH(WIDTH)) shift_i (
        .op(op_q), .x(shf_x), .amt(shf_amt), .z(shf_z)
    );

    // result selector
    logic [WIDTH-1:0] res_d;
    logic             cout_d;
    always_comb begin
        unique case (op_q)
            OP_ADD, OP_SUB:         begin res_d = add_z; cout_d = add_co; end
            OP_AND, OP_OR, OP_XOR:  begin res_d = log_z; cout_d = 1'b0;   end
            OP_SLL, OP_SRL, OP_SRA: begin res_d = shf_z; cout_d = 1'b0;   end
            default:                begin res_d = add_z; cout_d = 1'b0;   end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            res_q  <= res_d;
            cout_q <= cout_d;
        end
    end

    // adder matches arithmetic sum (R9)
    p_prefix_sum_r9: assert property (@(posedge clk) disable iff (rst)
        sel_add |-> ({add_co, add_z} == ({1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin})));

    // carry stays low for non-arithmetic opcodes (R6)
    p_carry_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_add |=> !cout_q);

    // reset clears outputs (R7)
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (res_q == '0) && !cout_q);

    if (GATE_IDLE) begin : g_gate_chk
        p_idle_add_r8: assert property (@(posedge clk) disable iff (rst)
            !sel_add |-> (add_z == '0) && !add_co);
        p_idle_log_r8: assert property (@(posedge clk) disable iff (rst)
            !sel_log |-> (log_z == '0));
        p_idle_shf_r8: assert property (@(posedge clk) disable iff (rst)
            !sel_shf |-> (shf_z == '0));
    end
endmodule

// File: tb/gated_alu_tb_top.sv
`timescale 1ns/1ps
module gated_alu_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic [7:0]  a8, b8, r8;
    logic [2:0]  op8, op32;
    logic [31:0] a32, b32, r32;
    logic        c8, c32;

    int checks = 0;
    int errors = 0;

    gated_alu #(.WIDTH(8), .GATE_IDLE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .a_in(a8), .b_in(b8), .op_in(op8),
        .res_q(r8), .cout_q(c8)
    );
    gated_alu #(.WIDTH(32), .GATE_IDLE(1'b1)) dut32_i (
        .clk(clk), .rst(rst), .a_in(a32), .b_in(b32), .op_in(op32),
        .res_q(r32), .cout_q(c32)
    );

    // reference: {carry, result} for width w
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op, input int w);
        logic [63:0] mask, s, sx;
        int sh;
        logic c;
        mask = (64'd1 << w) - 64'd1;
        sh   = int'(b) & (w - 1);
        c    = 1'b0;
        case (op)
            3'd0: begin s = {32'd0, a} + {32'd0, b}; c = s[w]; end
            3'd1: begin s = {32'd0, a} + ((~{32'd0, b}) & mask) + 64'd1; c = s[w]; end
            3'd2: s = {32'd0, a & b};
            3'd3: s = {32'd0, a | b};
            3'd4: s = {32'd0, a ^ b};
            3'd5: s = {32'd0, a} << sh;
            3'd6: s = {32'd0, a} >> sh;
            default: begin
                sx = a[w-1] ? ({32'd0, a} | ~mask) : {32'd0, a};
                s  = sx >> sh;
            end
        endcase
        s = s & mask;
        return {c, s[31:0]};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3, 3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
        logic [32:0] e;
        @(negedge clk); a8 = a; b8 = b; op8 = op;
        @(posedge clk); @(posedge clk); @(negedge clk);
        e = model({24'd0, a}, {24'd0, b}, op, 8);
        check(req_of(op), {c8, 24'd0, r8}, e);
        if (op > 3'd1) check("R6", {32'd0, c8}, 33'd0);
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        @(negedge clk); a32 = a; b32 = b; op32 = op;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(req_of(op), {c32, r32}, model(a, b, op, 32));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; a8 = 8'hA5; b8 = 8'h5A; op8 = 3'd0;
        a32 = 32'hFFFF_0000; b32 = 32'h1234_5678; op32 = 3'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        check("R7", {c8, 24'd0, r8}, 33'd0);
        check("R7", {c32, r32}, 33'd0);
        rst = 1'b0;

        // R1 latency: old value visible after first edge, new after second
        @(negedge clk); a32 = 32'd5; b32 = 32'd7; op32 = 3'd0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        @(negedge clk); a32 = 32'd100; b32 = 32'd1; op32 = 3'd1;
        @(posedge clk); @(negedge clk);
        check("R1", {c32, r32}, {1'b0, 32'd12});
        @(posedge clk); @(negedge clk);
        check("R1", {c32, r32}, {1'b1, 32'd99});

        // R2 full-width carry chain, R3 borrow, R5 shift corners at 32 bits
        run32(32'hFFFF_FFFF, 32'd1, 3'd0);
        run32(32'h8000_0000, 32'h8000_0000, 3'd0);
        run32(32'h7FFF_FFFF, 32'd1, 3'd0);
        run32(32'd0, 32'd1, 3'd1);
        run32(32'd7, 32'd7, 3'd1);
        run32(32'h8000_0001, 32'd0, 3'd5);
        run32(32'h8000_0001, 32'd31, 3'd5);
        run32(32'h8000_0001, 32'd31, 3'd6);
        run32(32'h8000_0001, 32'd31, 3'd7);
        run32(32'h8000_0001, 32'd0, 3'd7);
        run32(32'h4000_0000, 32'hFFFF_FFFE, 3'd7);
        run32(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd4);

        // R8 gating transparent: sweep at 8 bits, all a, b stepping 17, all opcodes
        for (int op = 0; op < 8; op++)
            for (int bb = 0; bb < 16; bb++)
                for (int aa = 0; aa < 256; aa++)
                    run8(8'(aa), 8'(bb * 17), 3'(op));

        // R7 mid-run reset after a nonzero result
        run32(32'hFFFF_FFFF, 32'd2, 3'd0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R7", {c32, r32}, 33'd0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule